// File: doc/BRIEF.md
# I2C GPIO Expander Target

This block is an I2C target that gives a bus controller byte-wide access to a bank of board status inputs and a bank of control outputs. The controller addresses it at 7-bit address 0x20. It then sends a register index, which the target latches. A following data byte goes to the output bank. A repeated START followed by a read fetches a byte from the input bank. The same indices 0x00 to 0x03 select the input bank on reads and the output bank on writes, so a read never returns what was written.

The input bank is mostly constant. Byte 0 holds a firmware revision value that is fixed when the block is built. Byte 2 carries three live status pins, and every other input bit reads 0. The output bank drives the LED control bits and the sequencing pin for the rest of the board.

SCL and SDA are sampled through two-stage synchronisers on the system clock, and all edges are detected after synchronisation. The target never drives SCL. It pulls SDA low only when it acknowledges a byte or sends a 0 data bit.

Top module: `i2c_gpio_target`

## Requirements
- R1: The target acknowledges an address byte only when its upper seven bits equal DEV_ADDR (default 0x20). For any other address the target leaves SDA released for the whole transaction.
- R2: A write transaction has three bytes: the address byte with bit 0 = 0, an index byte, and a data byte. When the index is below 4, the data byte replaces `gpio_out[8*index+7 : 8*index]`. Each of the three bytes is acknowledged.
- R3: A read transaction starts with a write of the index byte. A repeated START and the address byte with bit 0 = 1 follow. The target then sends the selected input byte MSB first.
- R4: Input byte 0 reads as the parameter FW_REV.
- R5: Input byte 2 reads as {5'b0, boot_i, pgood_i, seq_i}. Bit 0 is `seq_i`, bit 1 is `pgood_i` and bit 2 is `boot_i`, sampled when the byte is loaded. Input bytes 1 and 3 read 0x00.
- R6: Writes never alter the value returned by a read of the same index.
- R7: An index above 3 is acknowledged. A write with such an index leaves `gpio_out` unchanged, and a read with such an index returns 0x00.
- R8: After reset, `gpio_out` equals 0x00000003 (bits 0 and 1 set, all other bits clear) and `sda_oe` is 0.
- R9: `sda_oe` changes only while SCL is low. It is 0 whenever the target is idle.
- R10: When the controller acknowledges a read byte, the target sends the same register again. Further data bytes in one write go to the same register, and the last one wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line as seen at the pin |
| sda_i | input | 1 | I2C data line as seen at the pin |
| sda_oe | output | 1 | Pulls SDA low when 1; the line is released when 0 |
| seq_i | input | 1 | Sequencing pin state, input bit 16 |
| pgood_i | input | 1 | Power-good status, input bit 17 |
| boot_i | input | 1 | Boot-mode pin, input bit 18 |
| gpio_out | output | 8*NREG | Output bank; bits 1:0 are LED control and bit 16 is the sequencing drive |

## Verification
The bench builds the block with the default address 0x20, four registers, and FW_REV set to 0x5A. With that revision value, the revision byte drives SDA to both 0 and 1 within one read. Because the register map is this small, the bench can sweep all 128 addresses, every index from 0 to 7 for both reads and writes, and all eight combinations of the three status pins. This reaches every decode branch of the map, including the out-of-range indices.

// File: rtl/i2c_gpio_target.sv
module i2c_gpio_target #(
  parameter logic [6:0] DEV_ADDR = 7'h20,
  parameter logic [7:0] FW_REV   = 8'h02,
  parameter int         NREG     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              seq_i,
  input  logic              pgood_i,
  input  logic              boot_i,
  output logic [8*NREG-1:0] gpio_out
);
  localparam int OW = 8 * NREG;
  localparam int IW = $clog2(NREG);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_IDX, S_WR, S_RD, S_MACK} st_t;

  st_t           st;
  logic [2:0]    scl_r, sda_r;
  logic [3:0]    bitcnt;
  logic [7:0]    shreg, tx, idx, rd_byte;
  logic          rw, ack_go, in_ack;
  logic [OW-1:0] out_q, in_vec;

  wire scl_q = scl_r[1], scl_p = scl_r[2];
  wire sda_q = sda_r[1], sda_p = sda_r[2];
  wire scl_rise = scl_q & ~scl_p;
  wire scl_fall = ~scl_q & scl_p;
  wire start_c  = scl_q & scl_p & sda_p & ~sda_q;
  wire stop_c   = scl_q & scl_p & ~sda_p & sda_q;
  wire [7:0] rx_byte = {shreg[6:0], sda_q};
  wire idx_ok = idx < NREG;

  assign gpio_out = out_q;

  always_comb begin
    in_vec        = '0;
    in_vec[7:0]   = FW_REV;
    in_vec[18:16] = {boot_i, pgood_i, seq_i};
    rd_byte       = idx_ok ? in_vec[idx[IW-1:0]*8 +: 8] : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_r <= '1;
      sda_r <= '1;
    end else begin
      scl_r <= {scl_r[1:0], scl_i};
      sda_r <= {sda_r[1:0], sda_i};
    end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      bitcnt <= '0;
      shreg  <= '0;
      tx     <= '0;
      idx    <= '0;
      rw     <= 1'b0;
      ack_go <= 1'b0;
      in_ack <= 1'b0;
      sda_oe <= 1'b0;
      out_q  <= OW'(3);
    end else if (start_c) begin
      st     <= S_ADDR;
      bitcnt <= '0;
      ack_go <= 1'b0;
      in_ack <= 1'b0;
      sda_oe <= 1'b0;
    end else if (stop_c) begin
      st     <= S_IDLE;
      ack_go <= 1'b0;
      in_ack <= 1'b0;
      sda_oe <= 1'b0;
    end else if (scl_rise) begin
      if (!in_ack) begin
        case (st)
          S_ADDR, S_IDX, S_WR: begin
            shreg  <= rx_byte;
            bitcnt <= bitcnt + 4'd1;
            if (bitcnt == 4'd7) begin
              case (st)
                S_ADDR:
                  if (rx_byte[7:1] == DEV_ADDR) begin
                    ack_go <= 1'b1;
                    rw     <= rx_byte[0];
                  end else st <= S_IDLE;
                S_IDX: begin
                  idx    <= rx_byte;
                  ack_go <= 1'b1;
                end
                default: begin
                  if (idx_ok) out_q[idx[IW-1:0]*8 +: 8] <= rx_byte;
                  ack_go <= 1'b1;
                end
              endcase
            end
          end
          S_RD: begin
            tx     <= {tx[6:0], 1'b0};
            bitcnt <= bitcnt + 4'd1;
          end
          S_MACK:
            if (!sda_q) begin
              st     <= S_RD;
              bitcnt <= '0;
              tx     <= rd_byte;
            end else st <= S_IDLE;
          default: ;
        endcase
      end
    end else if (scl_fall) begin
      if (ack_go) begin
        sda_oe <= 1'b1;
        ack_go <= 1'b0;
        in_ack <= 1'b1;
      end else if (in_ack) begin
        in_ack <= 1'b0;
        bitcnt <= '0;
        if (st == S_ADDR && rw) begin
          st     <= S_RD;
          tx     <= rd_byte;
          sda_oe <= ~rd_byte[7];
        end else begin
          sda_oe <= 1'b0;
          if (st == S_ADDR)     st <= S_IDX;
          else if (st == S_IDX) st <= S_WR;
        end
      end else if (st == S_RD) begin
        if (bitcnt == 4'd8) begin
          sda_oe <= 1'b0;
          st     <= S_MACK;
        end else sda_oe <= ~tx[7];
      end
    end
  end

  AST_RESET_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (out_q == OW'(3) && !sda_oe)); // R8
  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_q); // R9
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_oe); // R1
  AST_OUT_ON_SCL_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_q) |-> $past(scl_rise)); // R2
  AST_BITCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt <= 4'd8); // R3
endmodule

// File: tb/sim_i2c_gpio_target.sv
module sim_i2c_gpio_target;
  localparam int QT = 5;
  localparam logic [7:0] REV = 8'h5A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic seq = 1'b0, pg = 1'b0, boot = 1'b0;
  logic sda_oe;
  logic [31:0] gpio_out;
  logic sda_bus;
  assign sda_bus = sda_m & ~sda_oe;

  int n_chk = 0, n_fail = 0, viol = 0;
  logic oe_prev = 1'b0;

  always #2 clk = ~clk;

  i2c_gpio_target #(.DEV_ADDR(7'h20), .FW_REV(REV), .NREG(4)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .seq_i(seq), .pgood_i(pg), .boot_i(boot), .gpio_out(gpio_out));

  always @(negedge clk) begin
    if (rst_n && scl && sda_oe !== oe_prev) viol++;
    oe_prev <= sda_oe;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic q();
    repeat (QT) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; q(); scl = 1'b1; q(); sda_m = 1'b0; q(); scl = 1'b0; q();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; q(); scl = 1'b1; q(); sda_m = 1'b1; q();
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; q(); scl = 1'b1; q(); scl = 1'b0; q();
    end
    sda_m = 1'b1; q(); scl = 1'b1; q(); ack = ~sda_bus; scl = 1'b0; q();
  endtask

  task automatic rd_byte(input bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      q(); scl = 1'b1; q(); b[i] = sda_bus; scl = 1'b0;
    end
    q(); sda_m = ~mack; q(); scl = 1'b1; q(); scl = 1'b0; q(); sda_m = 1'b1;
  endtask

  task automatic do_write(input logic [7:0] ix, input logic [7:0] d, input string req);
    logic a0, a1, a2;
    i2c_start(); wr_byte(8'h40, a0); wr_byte(ix, a1); wr_byte(d, a2); i2c_stop();
    check(a0 && a1 && a2, req, {29'b0, a0, a1, a2}, 32'h7);
  endtask

  task automatic do_read(input logic [7:0] ix, input int nbytes, output logic [7:0] r0, output logic [7:0] r1);
    logic a0, a1, a2;
    i2c_start(); wr_byte(8'h40, a0); wr_byte(ix, a1);
    i2c_start(); wr_byte(8'h41, a2);
    rd_byte(nbytes > 1, r0);
    r1 = r0;
    if (nbytes > 1) rd_byte(1'b0, r1);
    i2c_stop();
    check(a0 && a1 && a2, "R3", {29'b0, a0, a1, a2}, 32'h7);
  endtask

  function automatic logic [7:0] exp_in(input int ix, input logic s, input logic p, input logic bt);
    if (ix == 0) return REV;
    if (ix == 2) return {5'b0, bt, p, s};
    return 8'h00;
  endfunction

  logic [31:0] model;

  initial begin
    logic [7:0] r0, r1;
    logic ack;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(gpio_out == 32'h3, "R8", gpio_out, 32'h3);
    check(sda_oe == 1'b0, "R8", {31'b0, sda_oe}, 32'h0);
    model = 32'h3;

    for (int a = 0; a < 128; a++) begin
      i2c_start(); wr_byte({a[6:0], 1'b0}, ack); i2c_stop();
      check(ack == (a == 32'h20), "R1", {31'b0, ack}, {31'b0, a == 32'h20});
    end

    for (int ix = 0; ix < 8; ix++) begin
      for (int k = 0; k < 4; k++) begin
        logic [7:0] d;
        d = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : (k == 2) ? 8'h5A : 8'(ix * 37 + 1);
        do_write(8'(ix), d, ix > 3 ? "R7" : "R2");
        if (ix < 4) model[ix*8 +: 8] = d;
        check(gpio_out == model, ix > 3 ? "R7" : "R2", gpio_out, model);
      end
    end

    i2c_start(); wr_byte(8'h40, ack); wr_byte(8'h01, ack);
    wr_byte(8'h11, ack); wr_byte(8'h22, ack); i2c_stop();
    model[15:8] = 8'h22;
    check(gpio_out == model, "R10", gpio_out, model);

    for (int ix = 0; ix < 4; ix++) begin
      do_write(8'(ix), 8'hFF, "R2");
      model[ix*8 +: 8] = 8'hFF;
    end
    check(gpio_out == model, "R2", gpio_out, model);

    for (int s = 0; s < 8; s++) begin
      seq = s[0]; pg = s[1]; boot = s[2];
      for (int ix = 0; ix < 8; ix++) begin
        logic [7:0] e;
        e = exp_in(ix, s[0], s[1], s[2]);
        do_read(8'(ix), 1, r0, r1);
        check(r0 == e, ix == 0 ? "R4" : ix == 2 ? "R5" : ix > 3 ? "R7" : "R3", {24'b0, r0}, {24'b0, e});
      end
    end

    seq = 1'b1; pg = 1'b0; boot = 1'b1;
    do_read(8'h02, 1, r0, r1);
    check(r0 == 8'h05, "R6", {24'b0, r0}, 32'h05);
    check(gpio_out == model, "R6", gpio_out, model);

    do_read(8'h00, 2, r0, r1);
    check(r0 == REV && r1 == REV, "R10", {16'b0, r0, r1}, {16'b0, REV, REV});

    check(sda_oe == 1'b0, "R9", {31'b0, sda_oe}, 32'h0);
    check(viol == 0, "R9", viol, 32'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule